// File: doc/BRIEF.md
# Three-Class Interrupt Entry Controller

This block sits beside a processor pipeline and handles interrupt entry and return. The pipeline raises a request line for each of three interrupt classes: non-critical, critical and debug. With each request it supplies a vector index and a cause word. It also supplies the address where execution should resume. Each clock, the controller chooses at most one request that is allowed to proceed. It copies the resume address and the current status word into the save pair owned by the class it chose, and writes the cause word into a shared syndrome register. It then drops the processor into supervisor mode, masks the class it entered together with every class below it, and redirects fetch to the handler.

The handler address comes from a shared prefix register and one of sixteen offset registers, picked by the vector index. Each class has its own return strobe. A return copies that class's saved status back into the status word and sends fetch to that class's saved address. One parameter chooses whether debug gets its own save pair. When it does not, debug entries and debug returns use the critical pair. A small register port lets software read and write the prefix, the offsets, the syndrome, the status word and the save pairs.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset, the status word, syndrome, prefix, offsets and all save registers are zero, and `redirect` is low.
- R2: When several requests may be taken in the same cycle, debug wins over critical, and critical wins over non-critical.
- R3: Status bit 1 enables non-critical requests, bit 2 enables critical requests and bit 3 enables debug requests. A request whose enable is clear is not taken. It is taken once software sets the enable while the request is still held.
- R4: On entry, `cur_pc` and the status word from before entry are stored in the entered class's save pair. In the next cycle `redirect` pulses for one cycle and `entry_cls` gives the class (1 non-critical, 2 critical, 3 debug).
- R5: On entry, status bit 0 (user mode) is cleared. The enable of the entered class and the enables of all lower classes are cleared. Enables of higher classes are kept.
- R6: The handler address is prefix[31:16], then offset[n][15:4], then four zero bits. n is the vector index supplied with the request that was taken.
- R7: On entry, the syndrome register takes the cause word supplied with the request that was taken.
- R8: A critical entry taken during a non-critical handler leaves the non-critical pair unchanged. A debug entry taken during a critical handler leaves the critical pair unchanged.
- R9: A return strobe for a class loads the status word from that class's saved status. In the next cycle it pulses `redirect` with `redirect_pc` set to that class's saved address and `entry_cls` set to 0.
- R10: With `DBG_PAIR`=0, debug entry and debug return use the critical pair. Addresses 0x08 and 0x09 then read as zero.
- R11: Register map: 0x00 prefix, 0x01 syndrome, 0x02 status, 0x04/0x05 non-critical address/status, 0x06/0x07 critical address/status, 0x08/0x09 debug address/status, 0x20+n offset n. A write takes effect at the clock edge. A read returns the data combinationally in the same cycle.
- R12: If an entry and a return strobe happen in the same cycle, the entry is performed and the return is ignored. If an entry and a software write hit the same register in the same cycle, the entry's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_nc | input | 1 | Non-critical request (level) |
| req_cr | input | 1 | Critical request (level) |
| req_db | input | 1 | Debug request (level) |
| vec_nc | input | 4 | Offset index for non-critical request |
| vec_cr | input | 4 | Offset index for critical request |
| vec_db | input | 4 | Offset index for debug request |
| syn_nc | input | 32 | Cause word for non-critical request |
| syn_cr | input | 32 | Cause word for critical request |
| syn_db | input | 32 | Cause word for debug request |
| cur_pc | input | 32 | Resume address saved on entry |
| ret_nc | input | 1 | Non-critical return strobe |
| ret_cr | input | 1 | Critical return strobe |
| ret_db | input | 1 | Debug return strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| status | output | 32 | Current status word |
| redirect | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Fetch target |
| entry_cls | output | 2 | Class entered, 0 for a return |

## Verification
The hardest situation to reach from the ports is nesting. It needs one class's save pair to hold live state while a higher class enters. Each entry clears its own enable and the enables below it, so the stimulus acts as the handler would: after each entry it re-arms only the higher enable through the register port, while keeping the lower request asserted. The bench then checks that the outer pair survives. Collisions are created by driving a return strobe and a software write to a save register in the same cycle as an entry.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_NC   = 2'd1,
        CLS_CR   = 2'd2,
        CLS_DB   = 2'd3
    } irq_class_e;

    localparam int ST_USR = 0;
    localparam int ST_EE  = 1;
    localparam int ST_CE  = 2;
    localparam int ST_DE  = 3;

    localparam int ADR_PREFIX = 0;
    localparam int ADR_SYN    = 1;
    localparam int ADR_STATUS = 2;
    localparam int ADR_PAIR0  = 4;
    localparam int ADR_OFS0   = 32;
endpackage

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pkg::*;
(
    input  logic [2:0] req,
    input  logic [2:0] en,
    output irq_class_e grant
);
    logic [2:0] elig;

    for (genvar k = 0; k < 3; k++) begin : g_elig
        assign elig[k] = req[k] & en[k];
    end

    always_comb begin
        grant = CLS_NONE;
        if (elig[2])      grant = CLS_DB;
        else if (elig[1]) grant = CLS_CR;
        else if (elig[0]) grant = CLS_NC;
    end
endmodule

// File: rtl/irq_vec.sv
module irq_vec
    import irq_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_VEC = 16,
    parameter int AW      = 6,
    parameter int PFX_LSB = 16,
    parameter int ALIGN   = 4,
    localparam int IDX_W  = $clog2(NUM_VEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [AW-1:0]    sw_addr,
    input  logic [XLEN-1:0]  sw_wdata,
    output logic [XLEN-1:0]  sw_rdata,
    output logic             sw_hit,
    input  logic [IDX_W-1:0] sel,
    output logic [XLEN-1:0]  handler
);
    typedef struct packed {
        logic [XLEN-1:0]               prefix;
        logic [NUM_VEC-1:0][XLEN-1:0]  ofs;
    } vec_t;

    vec_t vs_d, vs_q;
    logic [NUM_VEC-1:0] ofs_hit;
    logic               pfx_hit;

    assign pfx_hit = (sw_addr == AW'(ADR_PREFIX));

    for (genvar n = 0; n < NUM_VEC; n++) begin : g_ofs_dec
        assign ofs_hit[n] = (sw_addr == AW'(ADR_OFS0 + n));
    end

    always_comb begin
        vs_d = vs_q;
        if (sw_we && pfx_hit) vs_d.prefix = sw_wdata;
        for (int n = 0; n < NUM_VEC; n++) begin
            if (sw_we && ofs_hit[n]) vs_d.ofs[n] = sw_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vs_q <= '0;
        else        vs_q <= vs_d;
    end

    always_comb begin
        sw_rdata = '0;
        sw_hit   = pfx_hit;
        if (pfx_hit) sw_rdata = vs_q.prefix;
        for (int n = 0; n < NUM_VEC; n++) begin
            if (ofs_hit[n]) begin
                sw_rdata = vs_q.ofs[n];
                sw_hit   = 1'b1;
            end
        end
    end

    assign handler = {vs_q.prefix[XLEN-1:PFX_LSB],
                      vs_q.ofs[sel][PFX_LSB-1:ALIGN],
                      {ALIGN{1'b0}}};

    // R11
    prefix_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && pfx_hit) |=> (vs_q.prefix == $past(sw_wdata)));
endmodule

// File: rtl/irq_save.sv
module irq_save
    import irq_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int AW       = 6,
    parameter bit DBG_PAIR = 1'b1,
    localparam int NPAIR   = DBG_PAIR ? 3 : 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_we,
    input  irq_class_e      hw_cls,
    input  logic [XLEN-1:0] hw_pc,
    input  logic [XLEN-1:0] hw_st,
    input  logic            sw_we,
    input  logic [AW-1:0]   sw_addr,
    input  logic [XLEN-1:0] sw_wdata,
    output logic [XLEN-1:0] sw_rdata,
    output logic            sw_hit,
    input  irq_class_e      rt_cls,
    output logic [XLEN-1:0] rt_pc,
    output logic [XLEN-1:0] rt_st
);
    typedef struct packed {
        logic [NPAIR-1:0][XLEN-1:0] pc;
        logic [NPAIR-1:0][XLEN-1:0] st;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [NPAIR-1:0] hit_pc, hit_st;
    logic [1:0]       hw_idx, rt_idx;

    function automatic logic [1:0] pair_of(input irq_class_e c);
        case (c)
            CLS_CR:  pair_of = 2'd1;
            CLS_DB:  pair_of = DBG_PAIR ? 2'd2 : 2'd1;
            default: pair_of = 2'd0;
        endcase
    endfunction

    assign hw_idx = pair_of(hw_cls);
    assign rt_idx = pair_of(rt_cls);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair_dec
        assign hit_pc[p] = (sw_addr == AW'(ADR_PAIR0 + 2 * p));
        assign hit_st[p] = (sw_addr == AW'(ADR_PAIR0 + 2 * p + 1));
    end

    always_comb begin
        bk_d = bk_q;
        for (int p = 0; p < NPAIR; p++) begin
            if (sw_we && hit_pc[p]) bk_d.pc[p] = sw_wdata;
            if (sw_we && hit_st[p]) bk_d.st[p] = sw_wdata;
        end
        if (hw_we) begin
            bk_d.pc[hw_idx] = hw_pc;
            bk_d.st[hw_idx] = hw_st;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    always_comb begin
        sw_rdata = '0;
        sw_hit   = 1'b0;
        for (int p = 0; p < NPAIR; p++) begin
            if (hit_pc[p]) begin
                sw_rdata = bk_q.pc[p];
                sw_hit   = 1'b1;
            end
            if (hit_st[p]) begin
                sw_rdata = bk_q.st[p];
                sw_hit   = 1'b1;
            end
        end
    end

    assign rt_pc = bk_q.pc[rt_idx];
    assign rt_st = bk_q.st[rt_idx];

    // R4
    save_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_we |=> (bk_q.pc[$past(hw_idx)] == $past(hw_pc)));
    // R4
    save_st_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_we |=> (bk_q.st[$past(hw_idx)] == $past(hw_st)));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int NUM_VEC  = 16,
    parameter int AW       = 6,
    parameter int PFX_LSB  = 16,
    parameter int ALIGN    = 4,
    parameter bit DBG_PAIR = 1'b1,
    localparam int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_nc,
    input  logic             req_cr,
    input  logic             req_db,
    input  logic [IDX_W-1:0] vec_nc,
    input  logic [IDX_W-1:0] vec_cr,
    input  logic [IDX_W-1:0] vec_db,
    input  logic [XLEN-1:0]  syn_nc,
    input  logic [XLEN-1:0]  syn_cr,
    input  logic [XLEN-1:0]  syn_db,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic             ret_nc,
    input  logic             ret_cr,
    input  logic             ret_db,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [XLEN-1:0]  reg_wdata,
    output logic [XLEN-1:0]  reg_rdata,
    output logic [XLEN-1:0]  status,
    output logic             redirect,
    output logic [XLEN-1:0]  redirect_pc,
    output logic [1:0]       entry_cls
);
    typedef struct packed {
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] syn;
        logic            redir;
        logic [XLEN-1:0] rpc;
        irq_class_e      cls;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    irq_class_e       grant, ret_cls;
    logic             take, ret_go;
    logic [2:0]       en_vec;
    logic [IDX_W-1:0] vsel;
    logic [XLEN-1:0]  handler, rt_pc, rt_st, csyn;
    logic [XLEN-1:0]  vec_rdata, sv_rdata;
    logic             vec_hit, sv_hit;

    assign en_vec = {ctl_q.status[ST_DE], ctl_q.status[ST_CE], ctl_q.status[ST_EE]};

    irq_arb u_arb (
        .req   ({req_db, req_cr, req_nc}),
        .en    (en_vec),
        .grant (grant)
    );

    assign take = (grant != CLS_NONE);

    always_comb begin
        ret_cls = CLS_NONE;
        if (ret_db)      ret_cls = CLS_DB;
        else if (ret_cr) ret_cls = CLS_CR;
        else if (ret_nc) ret_cls = CLS_NC;
    end

    assign ret_go = !take && (ret_cls != CLS_NONE);

    always_comb begin
        case (grant)
            CLS_DB:  begin vsel = vec_db; csyn = syn_db; end
            CLS_CR:  begin vsel = vec_cr; csyn = syn_cr; end
            default: begin vsel = vec_nc; csyn = syn_nc; end
        endcase
    end

    irq_vec #(
        .XLEN    (XLEN),
        .NUM_VEC (NUM_VEC),
        .AW      (AW),
        .PFX_LSB (PFX_LSB),
        .ALIGN   (ALIGN)
    ) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (reg_we),
        .sw_addr  (reg_addr),
        .sw_wdata (reg_wdata),
        .sw_rdata (vec_rdata),
        .sw_hit   (vec_hit),
        .sel      (vsel),
        .handler  (handler)
    );

    irq_save #(
        .XLEN     (XLEN),
        .AW       (AW),
        .DBG_PAIR (DBG_PAIR)
    ) u_save (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_we    (take),
        .hw_cls   (grant),
        .hw_pc    (cur_pc),
        .hw_st    (ctl_q.status),
        .sw_we    (reg_we),
        .sw_addr  (reg_addr),
        .sw_wdata (reg_wdata),
        .sw_rdata (sv_rdata),
        .sw_hit   (sv_hit),
        .rt_cls   (ret_cls),
        .rt_pc    (rt_pc),
        .rt_st    (rt_st)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.redir = 1'b0;
        ctl_d.cls   = CLS_NONE;
        if (reg_we && reg_addr == AW'(ADR_STATUS)) ctl_d.status = reg_wdata;
        if (reg_we && reg_addr == AW'(ADR_SYN))    ctl_d.syn    = reg_wdata;
        if (take) begin
            ctl_d.status         = ctl_q.status;
            ctl_d.status[ST_USR] = 1'b0;
            ctl_d.status[ST_EE]  = 1'b0;
            if (grant != CLS_NC) ctl_d.status[ST_CE] = 1'b0;
            if (grant == CLS_DB) ctl_d.status[ST_DE] = 1'b0;
            ctl_d.syn   = csyn;
            ctl_d.redir = 1'b1;
            ctl_d.rpc   = handler;
            ctl_d.cls   = grant;
        end else if (ret_go) begin
            ctl_d.status = rt_st;
            ctl_d.redir  = 1'b1;
            ctl_d.rpc    = rt_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(ADR_STATUS))   reg_rdata = ctl_q.status;
        else if (reg_addr == AW'(ADR_SYN)) reg_rdata = ctl_q.syn;
        else if (vec_hit)                  reg_rdata = vec_rdata;
        else if (sv_hit)                   reg_rdata = sv_rdata;
    end

    assign status      = ctl_q.status;
    assign redirect    = ctl_q.redir;
    assign redirect_pc = ctl_q.rpc;
    assign entry_cls   = ctl_q.cls;

    // R5
    entry_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !status[ST_USR]);
    // R5
    entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !status[ST_EE]);
    // R2
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == CLS_CR) |-> !(req_db && status[ST_DE]));
    // R3
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == CLS_NC) |-> status[ST_EE]);
    // R9
    ret_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_go |=> (redirect && entry_cls == 2'd0));
    // R4
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !ret_go) |=> !redirect);
endmodule

// File: tb/sim_irq_entry_ctrl.sv
module sim_irq_entry_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_nc = 0, req_cr = 0, req_db = 0;
    logic [3:0]  vec_nc = 0, vec_cr = 0, vec_db = 0;
    logic [31:0] syn_nc = 0, syn_cr = 0, syn_db = 0, cur_pc = 0;
    logic        ret_nc = 0, ret_cr = 0, ret_db = 0;
    logic        reg_we = 0;
    logic [5:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata, status, redirect_pc;
    logic        redirect;
    logic [1:0]  entry_cls;

    logic        b_req_db = 0, b_ret_db = 0, b_we = 0;
    logic [3:0]  b_vec_db = 0;
    logic [31:0] b_cur_pc = 0, b_wdata = 0;
    logic [5:0]  b_addr = 0;
    logic [31:0] b_rdata, b_status, b_rpc;
    logic        b_redirect;
    logic [1:0]  b_cls;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_nc(req_nc), .req_cr(req_cr), .req_db(req_db),
        .vec_nc(vec_nc), .vec_cr(vec_cr), .vec_db(vec_db),
        .syn_nc(syn_nc), .syn_cr(syn_cr), .syn_db(syn_db),
        .cur_pc(cur_pc),
        .ret_nc(ret_nc), .ret_cr(ret_cr), .ret_db(ret_db),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .status(status),
        .redirect(redirect), .redirect_pc(redirect_pc), .entry_cls(entry_cls)
    );

    irq_entry_ctrl #(.DBG_PAIR(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n),
        .req_nc(1'b0), .req_cr(1'b0), .req_db(b_req_db),
        .vec_nc(4'd0), .vec_cr(4'd0), .vec_db(b_vec_db),
        .syn_nc(32'd0), .syn_cr(32'd0), .syn_db(32'h0000_00EE),
        .cur_pc(b_cur_pc),
        .ret_nc(1'b0), .ret_cr(1'b0), .ret_db(b_ret_db),
        .reg_we(b_we), .reg_addr(b_addr), .reg_wdata(b_wdata),
        .reg_rdata(b_rdata), .status(b_status),
        .redirect(b_redirect), .redirect_pc(b_rpc), .entry_cls(b_cls)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic sw_wr(input logic [5:0] a, input logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic b_wr(input logic [5:0] a, input logic [31:0] d);
        b_we = 1; b_addr = a; b_wdata = d;
        step();
        b_we = 0;
    endtask

    task automatic b_rd(input logic [5:0] a, output logic [31:0] d);
        b_addr = a;
        #1;
        d = b_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 status", status, 32'h0);
        chk("R1 redirect", {31'd0, redirect}, 32'h0);
        rd(6'h00, v); chk("R1 prefix", v, 32'h0);
        rd(6'h01, v); chk("R1 syndrome", v, 32'h0);
        rd(6'h25, v); chk("R1 offset5", v, 32'h0);
        rd(6'h07, v); chk("R1 crit status save", v, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        sw_wr(6'h00, 32'hABCD_1234);
        sw_wr(6'h23, 32'h0000_5127);
        sw_wr(6'h29, 32'h0000_0A40);
        sw_wr(6'h2E, 32'hFFFF_7E5F);
        sw_wr(6'h01, 32'h0000_0055);
        sw_wr(6'h04, 32'h0000_1111);
        rd(6'h00, v); chk("R11 prefix", v, 32'hABCD_1234);
        rd(6'h23, v); chk("R11 offset3", v, 32'h0000_5127);
        rd(6'h2E, v); chk("R11 offset14", v, 32'hFFFF_7E5F);
        rd(6'h01, v); chk("R11 syndrome", v, 32'h0000_0055);
        rd(6'h04, v); chk("R11 nc addr", v, 32'h0000_1111);
    endtask

    task automatic t_entry_mask();
        logic [31:0] v;
        sw_wr(6'h02, 32'h1);
        vec_nc = 4'd3; syn_nc = 32'h0000_00C3; cur_pc = 32'h0000_4000; req_nc = 1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R3 masked no redirect", {31'd0, redirect}, 32'h0);
        end
        sw_wr(6'h02, 32'h3);
        chk("R3 still pending during enable write", {31'd0, redirect}, 32'h0);
        step();
        req_nc = 0;
        chk("R3 taken after enable", {31'd0, redirect}, 32'h1);
        chk("R4 entry class", {30'd0, entry_cls}, 32'h1);
        chk("R6 handler address", redirect_pc, 32'hABCD_5120);
        chk("R5 status after nc entry", status, 32'h0);
        rd(6'h01, v); chk("R7 syndrome", v, 32'h0000_00C3);
        rd(6'h04, v); chk("R4 saved address", v, 32'h0000_4000);
        rd(6'h05, v); chk("R4 saved status", v, 32'h3);
        step();
        chk("R4 redirect one cycle", {31'd0, redirect}, 32'h0);
    endtask

    task automatic t_nest();
        logic [31:0] v;
        sw_wr(6'h02, 32'h4);
        req_nc = 1; req_cr = 1; vec_cr = 4'd9; syn_cr = 32'h0000_00CC; cur_pc = 32'h0000_4100;
        step();
        req_cr = 0;
        chk("R8 crit entry class", {30'd0, entry_cls}, 32'h2);
        chk("R6 crit handler", redirect_pc, 32'hABCD_0A40);
        chk("R5 status after crit", status, 32'h0);
        rd(6'h04, v); chk("R8 nc pair kept", v, 32'h0000_4000);
        rd(6'h06, v); chk("R8 crit addr saved", v, 32'h0000_4100);
        rd(6'h07, v); chk("R8 crit status saved", v, 32'h4);
        sw_wr(6'h02, 32'h8);
        req_db = 1; vec_db = 4'd14; syn_db = 32'h0000_00DD; cur_pc = 32'h0000_4200;
        step();
        req_db = 0; req_nc = 0;
        chk("R8 debug entry class", {30'd0, entry_cls}, 32'h3);
        chk("R6 debug handler", redirect_pc, 32'hABCD_7E50);
        rd(6'h06, v); chk("R8 crit pair kept", v, 32'h0000_4100);
        rd(6'h08, v); chk("R8 debug addr saved", v, 32'h0000_4200);
        rd(6'h09, v); chk("R8 debug status saved", v, 32'h8);
        rd(6'h01, v); chk("R7 debug syndrome", v, 32'h0000_00DD);
    endtask

    task automatic t_prio();
        sw_wr(6'h02, 32'hE);
        req_nc = 1; req_cr = 1; req_db = 1; cur_pc = 32'h0000_5000;
        step();
        req_db = 0;
        chk("R2 debug wins", {30'd0, entry_cls}, 32'h3);
        chk("R5 debug clears all", status, 32'h0);
        sw_wr(6'h02, 32'hE);
        step();
        req_cr = 0;
        chk("R2 crit over nc", {30'd0, entry_cls}, 32'h2);
        chk("R5 debug enable kept", status, 32'h8);
        sw_wr(6'h02, 32'hA);
        step();
        req_nc = 0;
        chk("R2 nc alone", {30'd0, entry_cls}, 32'h1);
        chk("R5 nc entry keeps de", status, 32'h8);
    endtask

    task automatic t_return();
        sw_wr(6'h04, 32'h0000_6000);
        sw_wr(6'h05, 32'h0000_0003);
        ret_nc = 1; step(); ret_nc = 0;
        chk("R9 nc return redirect", {31'd0, redirect}, 32'h1);
        chk("R9 nc return pc", redirect_pc, 32'h0000_6000);
        chk("R9 nc return status", status, 32'h3);
        chk("R9 nc return class", {30'd0, entry_cls}, 32'h0);
        sw_wr(6'h06, 32'h0000_6100);
        sw_wr(6'h07, 32'h0000_0005);
        ret_cr = 1; step(); ret_cr = 0;
        chk("R9 crit return pc", redirect_pc, 32'h0000_6100);
        chk("R9 crit return status", status, 32'h5);
        sw_wr(6'h08, 32'h0000_6200);
        sw_wr(6'h09, 32'h0000_000B);
        ret_db = 1; step(); ret_db = 0;
        chk("R9 debug return pc", redirect_pc, 32'h0000_6200);
        chk("R9 debug return status", status, 32'hB);
    endtask

    task automatic t_conflict();
        logic [31:0] v;
        sw_wr(6'h07, 32'h0000_000F);
        req_nc = 1; vec_nc = 4'd3; syn_nc = 32'h0000_0077; cur_pc = 32'h0000_7000; ret_cr = 1;
        reg_we = 1; reg_addr = 6'h04; reg_wdata = 32'hDEAD_0000;
        step();
        req_nc = 0; ret_cr = 0; reg_we = 0;
        chk("R12 entry over return class", {30'd0, entry_cls}, 32'h1);
        chk("R12 entry over return pc", redirect_pc, 32'hABCD_5120);
        chk("R12 return status ignored", status, 32'h8);
        rd(6'h04, v); chk("R12 hw over sw write", v, 32'h0000_7000);
        rd(6'h05, v); chk("R12 saved status", v, 32'hB);
    endtask

    task automatic t_nodbg();
        logic [31:0] v;
        b_wr(6'h00, 32'h1234_0000);
        b_wr(6'h22, 32'h0000_0330);
        b_wr(6'h02, 32'h9);
        b_req_db = 1; b_vec_db = 4'd2; b_cur_pc = 32'h0000_8000;
        step();
        b_req_db = 0;
        chk("R10 debug entry class", {30'd0, b_cls}, 32'h3);
        chk("R10 debug handler", b_rpc, 32'h1234_0330);
        chk("R10 status cleared", b_status, 32'h0);
        b_rd(6'h06, v); chk("R10 crit pair addr", v, 32'h0000_8000);
        b_rd(6'h07, v); chk("R10 crit pair status", v, 32'h9);
        b_rd(6'h08, v); chk("R10 debug addr absent", v, 32'h0);
        b_ret_db = 1; step(); b_ret_db = 0;
        chk("R10 debug return pc", b_rpc, 32'h0000_8000);
        chk("R10 debug return status", b_status, 32'h9);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        rst_n = 1;
        step();
        t_reset();
        t_regs();
        t_entry_mask();
        t_nest();
        t_prio();
        t_return();
        t_conflict();
        t_nodbg();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule